// File: doc/BRIEF.md
# Latched Monitor Alarm Interrupt Controller

This block watches a four-lane optical transceiver's health. Ten 8-bit readings come from outside converters: module temperature, supply voltage, the laser bias of each lane and the received optical power of each lane. Each reading is compared against four thresholds of its own: a low and a high warning, and a low and a high alarm. The four results, together with per-lane transmit and receive loss-of-signal and transmit-fault inputs, set sticky flags. A flag stays set until the host reads the byte that holds it.

A byte-wide register port stands in for the management serial slave. Through it the host reads the flags, and reads or writes the interrupt masks, the per-lane squelch-disable and lane-off controls, and all forty thresholds. The active-low interrupt is driven by any latched flag whose mask bit is clear. The per-lane transmit and receive enables are derived from the latched loss, the latched fault and the host controls.

Top module: `mon_alarm_irq`

## Requirements
- R1: For reading index a (0 temperature, 1 supply, 2..5 bias lanes 0..3, 6..9 rx power lanes 0..3), threshold address 32+4a+k holds k=0 low warning, k=1 high warning, k=2 low alarm and k=3 high alarm. A reading below a low threshold or above a high threshold sets the flag at bit k of nibble a%2 of flag byte 2+a/2. The flag is set on the clock edge at which the condition is sampled.
- R2: Flag byte 0 holds transmit loss-of-signal for lanes 0..3 in bits 3:0 and receive loss-of-signal for lanes 0..3 in bits 7:4. An asserted loss input sets its bit.
- R3: Flag byte 1 bits 3:0 hold the transmit fault of lanes 0..3. Bits 7:4 of that byte always read zero.
- R4: A set flag stays set after its condition goes away, until its own flag byte is read.
- R5: A read of flag byte n (address n, 0..6) returns the flags as they were before the read and clears only that byte at the next edge. A condition still present at that edge sets its flag again.
- R6: Mask bytes at addresses 8..14 line up bit for bit with flag bytes 0..6. A masked flag never pulls the interrupt low.
- R7: irq_n is low exactly while some latched flag has a clear mask bit. It goes high right after the edge that clears or masks the last such flag.
- R8: tx_en[l] is low when lane l is switched off (address 16 bit l), when its latched fault is set, or when its latched transmit loss is set and transmit squelch-disable (address 15 bit l) is clear.
- R9: rx_en[l] is low when lane l is switched off, or when its latched receive loss is set and receive squelch-disable (address 15 bit 4+l) is clear.
- R10: Masks, controls and thresholds read back what was last written. Writes to flag bytes are ignored. Unmapped addresses read zero.
- R11: After reset all flags, masks and controls are zero, low thresholds are 0x00 and high thresholds 0xFF, irq_n is high, and every enable is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| temp_i | input | 8 | Temperature reading |
| vcc_i | input | 8 | Supply voltage reading |
| bias_i | input | 32 | Laser bias readings, lane l in bits 8l+7:8l |
| rxpwr_i | input | 32 | Received power readings, lane l in bits 8l+7:8l |
| tx_los_i | input | 4 | Transmit-side loss of input signal per lane |
| rx_los_i | input | 4 | Receive-side loss of optical signal per lane |
| tx_fault_i | input | 4 | Transmit fault per lane |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (clears a flag byte) |
| reg_addr | input | 7 | Register address |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for reg_addr, same cycle |
| irq_n | output | 1 | Active-low interrupt |
| tx_en | output | 4 | Per-lane transmit output enable |
| rx_en | output | 4 | Per-lane receive output enable |

## Verification
A directed walk moves the temperature reading through each of the four threshold bands in turn. Because a single excursion past both a warning and an alarm sets two bits, it separates warning from alarm comparison and low from high. Repeated reads while a condition persists, and while it has gone, distinguish clear-and-reset from plain clear-on-read. Mask toggles with a flag held show that the interrupt follows the mask without the flag moving. Single-lane loss and fault pulses with squelch-disable and lane-off settings show each lane's enables reacting only to their own lane. A long random phase with fresh readings, thresholds, masks and reads then exercises all ten comparators at once against a behavioural model.

// File: rtl/mon_alarm_irq.sv
`timescale 1ns/1ps
module mon_alarm_irq (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [7:0]  temp_i,
  input  logic [7:0]  vcc_i,
  input  logic [31:0] bias_i,
  input  logic [31:0] rxpwr_i,
  input  logic [3:0]  tx_los_i,
  input  logic [3:0]  rx_los_i,
  input  logic [3:0]  tx_fault_i,
  input  logic        reg_wr,
  input  logic        reg_rd,
  input  logic [6:0]  reg_addr,
  input  logic [7:0]  reg_wdata,
  output logic [7:0]  reg_rdata,
  output logic        irq_n,
  output logic [3:0]  tx_en,
  output logic [3:0]  rx_en
);
  localparam int NATTR = 10;
  localparam int NBYTE = 7;
  localparam int NFLAG = 8 * NBYTE;
  localparam int NTHR  = 4 * NATTR;

  logic [NFLAG-1:0] flags_q, mask_q, cond, clr;
  logic [7:0]       sqd_q;
  logic [3:0]       off_q;
  logic [7:0]       thr_q [NTHR];
  logic [8*NATTR-1:0] meas;
  logic [5:0]       thr_idx;
  logic             in_mask, in_thr;

  assign meas    = {rxpwr_i, bias_i, vcc_i, temp_i};
  assign thr_idx = 6'(reg_addr - 7'd32);
  assign in_mask = reg_addr >= 7'd8 && reg_addr <= 7'd14;
  assign in_thr  = reg_addr >= 7'd32 && reg_addr < 7'd72;

  assign cond[7:0]  = {rx_los_i, tx_los_i};
  assign cond[15:8] = {4'b0, tx_fault_i};

  for (genvar a = 0; a < NATTR; a++) begin : g_attr
    logic [7:0] v;
    assign v = meas[8*a +: 8];
    assign cond[16+4*a]   = v < thr_q[4*a];
    assign cond[16+4*a+1] = v > thr_q[4*a+1];
    assign cond[16+4*a+2] = v < thr_q[4*a+2];
    assign cond[16+4*a+3] = v > thr_q[4*a+3];
  end

  for (genvar r = 0; r < NBYTE; r++) begin : g_clr
    assign clr[8*r +: 8] = {8{reg_rd && reg_addr == 7'(r)}};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flags_q <= '0;
      mask_q  <= '0;
      sqd_q   <= '0;
      off_q   <= '0;
      for (int i = 0; i < NTHR; i++) thr_q[i] <= (i % 2 == 1) ? 8'hFF : 8'h00;
    end else begin
      flags_q <= (flags_q & ~clr) | cond;
      if (reg_wr) begin
        if (in_mask) mask_q[{reg_addr[2:0], 3'b000} +: 8] <= reg_wdata;
        if (reg_addr == 7'd15) sqd_q <= reg_wdata;
        if (reg_addr == 7'd16) off_q <= reg_wdata[3:0];
        if (in_thr) thr_q[thr_idx] <= reg_wdata;
      end
    end
  end

  always_comb begin
    reg_rdata = '0;
    if (reg_addr < 7'd7)        reg_rdata = flags_q[{reg_addr[2:0], 3'b000} +: 8];
    else if (in_mask)           reg_rdata = mask_q[{reg_addr[2:0], 3'b000} +: 8];
    else if (reg_addr == 7'd15) reg_rdata = sqd_q;
    else if (reg_addr == 7'd16) reg_rdata = {4'b0, off_q};
    else if (in_thr)            reg_rdata = thr_q[thr_idx];
  end

  assign irq_n = ~|(flags_q & ~mask_q);
  assign tx_en = ~off_q & ~flags_q[11:8] & ~(flags_q[3:0] & ~sqd_q[3:0]);
  assign rx_en = ~off_q & ~(flags_q[7:4] & ~sqd_q[7:4]);

  assert_cond_sets_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> (($past(cond) & ~flags_q) == '0));
  assert_sticky_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> (($past(flags_q) & ~$past(clr) & ~flags_q) == '0));
  assert_all_masked_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (&mask_q) |-> irq_n);
  assert_irq_source_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_n |-> (flags_q != '0));
  assert_fault_off_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(tx_fault_i) != 4'b0) |-> ((tx_en & $past(tx_fault_i)) == 4'b0));
  assert_off_rx_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(reg_wr) && $past(reg_addr) == 7'd16) |->
      ((rx_en & $past(reg_wdata[3:0])) == 4'b0));
endmodule

// File: tb/mon_alarm_irq_tb_top.sv
`timescale 1ns/1ps
module mon_alarm_irq_tb_top;
  logic        clk = 0, rst_n = 0;
  logic [7:0]  temp_i = 50, vcc_i = 50;
  logic [31:0] bias_i = {4{8'd50}}, rxpwr_i = {4{8'd50}};
  logic [3:0]  tx_los_i = 0, rx_los_i = 0, tx_fault_i = 0;
  logic        reg_wr = 0, reg_rd = 0;
  logic [6:0]  reg_addr = 0;
  logic [7:0]  reg_wdata = 0, reg_rdata;
  logic        irq_n;
  logic [3:0]  tx_en, rx_en;
  int vecs = 0, errs = 0, cyc = 0;
  bit done = 0;

  always #5 clk = ~clk;

  mon_alarm_irq dut_i (.clk(clk), .rst_n(rst_n), .temp_i(temp_i), .vcc_i(vcc_i),
    .bias_i(bias_i), .rxpwr_i(rxpwr_i), .tx_los_i(tx_los_i), .rx_los_i(rx_los_i),
    .tx_fault_i(tx_fault_i), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq_n(irq_n), .tx_en(tx_en), .rx_en(rx_en));

  // behavioural reference
  logic [7:0] m_fl [7];
  logic [7:0] m_mk [7];
  logic [7:0] m_thr [40];
  logic [7:0] m_sq = 0, m_off = 0;
  logic [7:0] c [7];
  int v, sh, rb;

  function automatic int rdg(int a);
    if (a == 0) return temp_i;
    if (a == 1) return vcc_i;
    if (a < 6) return bias_i[(a-2)*8 +: 8];
    return rxpwr_i[(a-6)*8 +: 8];
  endfunction

  initial begin
    for (int i = 0; i < 7; i++) begin m_fl[i] = 0; m_mk[i] = 0; end
    for (int i = 0; i < 40; i++) m_thr[i] = (i % 2 == 1) ? 8'hFF : 8'h00;
  end

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 7; i++) begin m_fl[i] = 0; m_mk[i] = 0; end
      for (int i = 0; i < 40; i++) m_thr[i] = (i % 2 == 1) ? 8'hFF : 8'h00;
      m_sq = 0; m_off = 0;
    end else begin
      c[0] = {rx_los_i, tx_los_i};
      c[1] = {4'b0, tx_fault_i};
      for (int r = 2; r < 7; r++) c[r] = 0;
      for (int a = 0; a < 10; a++) begin
        v = rdg(a); sh = (a % 2) * 4; rb = 2 + a / 2;
        if (v < int'(m_thr[4*a]))   c[rb][sh]   = 1'b1;
        if (v > int'(m_thr[4*a+1])) c[rb][sh+1] = 1'b1;
        if (v < int'(m_thr[4*a+2])) c[rb][sh+2] = 1'b1;
        if (v > int'(m_thr[4*a+3])) c[rb][sh+3] = 1'b1;
      end
      for (int r = 0; r < 7; r++)
        if (reg_rd && reg_addr == 7'(r)) m_fl[r] = c[r];
        else m_fl[r] = m_fl[r] | c[r];
      if (reg_wr) begin
        if (reg_addr >= 8 && reg_addr <= 14) m_mk[reg_addr - 8] = reg_wdata;
        if (reg_addr == 15) m_sq = reg_wdata;
        if (reg_addr == 16) m_off = {4'b0, reg_wdata[3:0]};
        if (reg_addr >= 32 && reg_addr < 72) m_thr[reg_addr - 32] = reg_wdata;
      end
    end
  end

  function automatic logic [7:0] exp_rd();
    if (reg_addr < 7) return m_fl[reg_addr];
    if (reg_addr >= 8 && reg_addr <= 14) return m_mk[reg_addr - 8];
    if (reg_addr == 15) return m_sq;
    if (reg_addr == 16) return m_off;
    if (reg_addr >= 32 && reg_addr < 72) return m_thr[reg_addr - 32];
    return 8'h00;
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int expv);
    vecs++;
    if (!ok) begin errs++; $display("FAIL %s actual %h expected %h", tag, act, expv); end
  endtask

  always @(negedge clk) if (rst_n && !done) begin
    logic eirq; logic [3:0] etx, erx; string t;
    eirq = 1;
    for (int r = 0; r < 7; r++) if ((m_fl[r] & ~m_mk[r]) != 0) eirq = 0;
    etx = ~m_off[3:0] & ~m_fl[1][3:0] & ~(m_fl[0][3:0] & ~m_sq[3:0]);
    erx = ~m_off[3:0] & ~(m_fl[0][7:4] & ~m_sq[7:4]);
    t = (reg_addr == 0) ? "R2 rdata" : (reg_addr == 1) ? "R3 rdata" :
        (reg_addr < 7) ? "R1 rdata" : "R10 rdata";
    chk(irq_n == eirq, "R7 irq_n", irq_n, eirq);
    chk(tx_en == etx, "R8 tx_en", tx_en, etx);
    chk(rx_en == erx, "R9 rx_en", rx_en, erx);
    chk(reg_rdata == exp_rd(), t, reg_rdata, exp_rd());
  end

  task automatic step(); @(posedge clk); #2; endtask
  task automatic wr(input int a, input int d);
    reg_wr = 1; reg_addr = 7'(a); reg_wdata = 8'(d); step(); reg_wr = 0;
  endtask
  task automatic rd_chk(input int a, input int e, input string tag);
    reg_rd = 1; reg_addr = 7'(a); #1;
    chk(reg_rdata == 8'(e), tag, reg_rdata, e);
    step(); reg_rd = 0; reg_addr = 7'd100;
  endtask

  task automatic finish_run();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !done) begin
      errs++; $display("FAIL watchdog actual %0d expected below 150000", cyc);
      finish_run();
    end
  end

  initial begin
    reg_addr = 7'd100;
    repeat (3) step();
    rst_n = 1; step(); #1;
    // R11 reset state
    chk(irq_n == 1, "R11 irq_n", irq_n, 1);
    chk(tx_en == 4'hF && rx_en == 4'hF, "R11 enables", {tx_en, rx_en}, 8'hFF);
    rd_chk(35, 8'hFF, "R11 high threshold");
    rd_chk(34, 8'h00, "R11 low threshold");
    rd_chk(2, 8'h00, "R11 flags");
    // R1 temperature bands
    wr(32, 20); wr(33, 80); wr(34, 10); wr(35, 90);
    temp_i = 85; step(); temp_i = 50; step(); step(); #1;
    chk(irq_n == 0, "R7 irq low with flag", irq_n, 0);
    rd_chk(2, 8'h02, "R4 high warning held");
    rd_chk(2, 8'h00, "R5 cleared");
    temp_i = 95; step();
    rd_chk(2, 8'h0A, "R1 warning and alarm");
    rd_chk(2, 8'h0A, "R5 reset while present");
    temp_i = 50; step();
    rd_chk(2, 8'h0A, "R4 sticky");
    rd_chk(2, 8'h00, "R5 cleared");
    temp_i = 5; step(); temp_i = 50;
    rd_chk(2, 8'h05, "R1 low warning and alarm");
    rd_chk(2, 8'h00, "R5 cleared");
    // R6 / R7 masking
    wr(10, 8'hFF); temp_i = 95; step(); temp_i = 50; #1;
    chk(irq_n == 1, "R6 masked flag", irq_n, 1);
    wr(10, 0); #1; chk(irq_n == 0, "R7 unmasked", irq_n, 0);
    wr(10, 8'hFF); #1; chk(irq_n == 1, "R7 masked again", irq_n, 1);
    rd_chk(2, 8'h0A, "R6 flag kept under mask");
    wr(10, 0); #1; chk(irq_n == 1, "R7 nothing pending", irq_n, 1);
    // R10 read-only flags
    wr(0, 8'hFF); rd_chk(0, 8'h00, "R10 flag write ignored");
    rd_chk(40, 8'h00, "R10 default low threshold");
    rd_chk(20, 8'h00, "R10 unmapped");
    // R2 / R8 transmit loss
    tx_los_i = 4'b0001; step(); tx_los_i = 0; step(); #1;
    chk(tx_en == 4'b1110, "R8 tx squelch", tx_en, 4'b1110);
    chk(irq_n == 0, "R2 loss interrupt", irq_n, 0);
    rd_chk(0, 8'h01, "R2 tx loss flag"); #1;
    chk(tx_en == 4'hF, "R8 tx restored", tx_en, 4'hF);
    wr(15, 8'h01); tx_los_i = 4'b0001; step(); tx_los_i = 0; step(); #1;
    chk(tx_en == 4'hF, "R8 squelch disabled", tx_en, 4'hF);
    rd_chk(0, 8'h01, "R2 flag with squelch off");
    wr(15, 0);
    // R9 receive loss and lane off
    rx_los_i = 4'b0100; step(); rx_los_i = 0; step(); #1;
    chk(rx_en == 4'b1011, "R9 rx squelch", rx_en, 4'b1011);
    rd_chk(0, 8'h40, "R2 rx loss flag");
    wr(16, 8'h08); #1;
    chk(tx_en == 4'b0111, "R8 lane off tx", tx_en, 4'b0111);
    chk(rx_en == 4'b0111, "R9 lane off rx", rx_en, 4'b0111);
    wr(16, 0);
    // R3 fault overrides squelch disable
    wr(15, 8'hFF); tx_fault_i = 4'b0010; step(); tx_fault_i = 0; step(); #1;
    chk(tx_en == 4'b1101, "R3 fault disables tx", tx_en, 4'b1101);
    rd_chk(1, 8'h02, "R3 fault flag");
    wr(15, 0);
    rd_chk(34, 8'd10, "R10 threshold readback");
    // random phase
    for (int i = 0; i < 3000; i++) begin
      int op;
      temp_i = 8'($urandom); vcc_i = 8'($urandom);
      bias_i = $urandom; rxpwr_i = $urandom;
      tx_los_i = ($urandom_range(0, 7) == 0) ? 4'($urandom) : 4'b0;
      rx_los_i = ($urandom_range(0, 7) == 0) ? 4'($urandom) : 4'b0;
      tx_fault_i = ($urandom_range(0, 15) == 0) ? 4'($urandom) : 4'b0;
      reg_rd = 0; reg_wr = 0; reg_wdata = 8'($urandom);
      op = $urandom_range(0, 9);
      if (op < 4) begin reg_rd = 1; reg_addr = ($urandom_range(0, 1) == 0) ? 7'($urandom_range(0, 16)) : 7'($urandom_range(32, 71)); end
      else if (op == 4) begin reg_wr = 1; reg_addr = 7'($urandom_range(32, 71)); end
      else if (op == 5) begin reg_wr = 1; reg_addr = 7'($urandom_range(8, 14)); end
      else if (op == 6) begin reg_wr = 1; reg_addr = 7'($urandom_range(15, 16)); end
      else reg_addr = 7'($urandom_range(0, 127));
      step();
    end
    reg_rd = 0; reg_wr = 0;
    step();
    finish_run();
  end
endmodule